// File: doc/BRIEF.md
# Pin-Cell Counting and Shifting Engine

This block is a small programmable engine that sits in a pin cell and counts or shifts a 32-bit accumulator under the control of two configuration words. Two input pins, called A and B, are each routed from a shared pin vector by their own select fields. On every active clock the engine compares the routed inputs against a pattern. When the pattern matches, the engine takes a 5-bit micro-opcode from the second word. When it does not match, it takes the opcode from the first word. The chosen opcode then updates the accumulator: it can set it to +1 or -1, increment it, decrement it, shift it right, shift it left, or hold it.

A one-bit state register is XORed into the low bit of the chosen opcode. The opcode table pairs each operation with its complement, and the two members of a pair differ only in that low bit. So one configuration counts or shifts in one direction in state 0 and in the opposite direction in state 1. The state flips only when the opcode requests it through its bit 3 and the enable bit for the path that was taken is set.

Two of the four engine modes also drive the cell's own output pin from the accumulator's low bit. Writing a configuration loads the mode, both words and both pin selects. The same write clears the accumulator and the state.

Top module: `pcsm_engine`

## Requirements
- R1: After reset the accumulator reads 0, the state is 0, the mode is 5'b00000 (idle), and both `out_en_o` and `out_o` are 0.
- R2: The engine decodes the low three bits of the effective opcode as follows: 3'b010 sets Z to 1, 3'b011 sets Z to all ones, 3'b100 adds 1, 3'b101 subtracts 1, 3'b110 shifts right with a zero filled in at the top, 3'b111 shifts left with a zero filled in at bit 0, and 3'b000 or 3'b001 hold Z. Opcode bit 4 has no effect.
- R3: In the 2-bit mode variants (mode[1]=0), a match occurs when {B,A} equals Y[28:27]. On a match the opcode is Y[25:21]; otherwise it is X[25:21].
- R4: In the 1-bit mode variants (mode[1]=1), a match occurs when A equals Y[27] in state 0, or equals Y[28] in state 1. B is not used in these modes.
- R5: The effective opcode is the selected opcode with its bit 0 XORed with the state bit.
- R6: After an update, the state flips when bit 3 of the effective opcode is 1 and the toggle enable of the path taken is 1 (Y[26] on a match, X[26] otherwise). If either of these is 0, the state holds.
- R7: A is pins_i[cfg_sel_a_i] and B is pins_i[cfg_sel_b_i].
- R8: Z updates once per clock only in modes 5'b10100, 5'b10101, 5'b10110 and 5'b10111; in any other mode Z holds. `out_en_o` is 1 only in modes 5'b10101 and 5'b10111, and in those modes `out_o` equals Z[0]; otherwise `out_o` is 0.
- R9: A cycle with `cfg_we_i` high loads the configuration and clears Z and the state, and it performs no opcode in that cycle.
- R10: Increment and decrement wrap modulo 2^32: all ones plus 1 gives 0, and 0 minus 1 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 5 | Mode to load |
| cfg_x_i | input | 32 | First configuration word (no-match opcode, its toggle enable) |
| cfg_y_i | input | 32 | Second configuration word (match opcode, its toggle enable, match pattern) |
| cfg_sel_a_i | input | 3 | Pin index routed to input A |
| cfg_sel_b_i | input | 3 | Pin index routed to input B |
| pins_i | input | 8 | Shared pin vector |
| z_o | output | 32 | Accumulator readback |
| out_en_o | output | 1 | Output pin enable |
| out_o | output | 1 | Output pin value |

## Verification
Every result appears one clock after the stimulus that causes it. Pins sampled at a rising edge update Z, the state and `out_o` at that same edge, and a configuration write shows a cleared Z at the edge that registers it. The bench therefore drives its inputs on the falling edge and reads the outputs at the next falling edge. A state flip is seen one cycle later, through the complementary operation or the changed match pattern that the next step selects.

// File: rtl/pcsm_pkg.sv
package pcsm_pkg;
    localparam int CFG_W    = 32;
    localparam int OP_W     = 5;
    localparam int OP_LSB   = 21;   // opcode field in both words
    localparam int TOG_BIT  = 26;   // toggle enable in both words
    localparam int PAT_LSB  = 27;   // match pattern in second word
    localparam int MODE_W   = 5;

    typedef enum logic [2:0] {
        OPK_HOLD0 = 3'b000,
        OPK_HOLD1 = 3'b001,
        OPK_SETP  = 3'b010,
        OPK_SETN  = 3'b011,
        OPK_INC   = 3'b100,
        OPK_DEC   = 3'b101,
        OPK_SHR   = 3'b110,
        OPK_SHL   = 3'b111
    } op_kind_e;
endpackage

// File: rtl/pcsm_route.sv
module pcsm_route #(
    parameter int NPIN = 8,
    localparam int SELW = $clog2(NPIN)
) (
    input  logic [NPIN-1:0] pins_i,
    input  logic [SELW-1:0] sel_a_i,
    input  logic [SELW-1:0] sel_b_i,
    output logic            a_o,
    output logic            b_o
);
    always_comb begin
        a_o = pins_i[sel_a_i];
        b_o = pins_i[sel_b_i];
    end
endmodule

// File: rtl/pcsm_opsel.sv
module pcsm_opsel
    import pcsm_pkg::*;
(
    input  logic                a_i,
    input  logic                b_i,
    input  logic                one_bit_i,
    input  logic                state_i,
    input  logic [CFG_W-1:0]    x_i,
    input  logic [CFG_W-1:0]    y_i,
    output logic                match_o,
    output logic [OP_W-1:0]     eff_op_o,
    output logic                toggle_o
);
    logic [OP_W-1:0] raw_op;
    logic [1:0]      pattern;
    logic            unused_bits;

    assign pattern     = y_i[PAT_LSB +: 2];
    assign unused_bits = ^{x_i[CFG_W-1:TOG_BIT+1], x_i[OP_LSB-1:0],
                           y_i[CFG_W-1:PAT_LSB+2], y_i[OP_LSB-1:0]};

    always_comb begin
        if (one_bit_i)
            match_o = (a_i == (state_i ? pattern[1] : pattern[0]));
        else
            match_o = ({b_i, a_i} == pattern);
        raw_op   = match_o ? y_i[OP_LSB +: OP_W] : x_i[OP_LSB +: OP_W];
        eff_op_o = {raw_op[OP_W-1:1], raw_op[0] ^ state_i};
        toggle_o = eff_op_o[3] & (match_o ? y_i[TOG_BIT] : x_i[TOG_BIT]);
    end
endmodule

// File: rtl/pcsm_alu.sv
module pcsm_alu
    import pcsm_pkg::*;
#(
    parameter int ZW = 32
) (
    input  logic [ZW-1:0] z_i,
    input  logic [2:0]    kind_i,
    output logic [ZW-1:0] z_o
);
    always_comb begin
        unique case (op_kind_e'(kind_i))
            OPK_SETP: z_o = ZW'(1);
            OPK_SETN: z_o = '1;
            OPK_INC:  z_o = z_i + ZW'(1);
            OPK_DEC:  z_o = z_i - ZW'(1);
            OPK_SHR:  z_o = {1'b0, z_i[ZW-1:1]};
            OPK_SHL:  z_o = {z_i[ZW-2:0], 1'b0};
            default:  z_o = z_i;
        endcase
    end
endmodule

// File: rtl/pcsm_engine.sv
module pcsm_engine
    import pcsm_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int ZW   = 32,
    localparam int SELW = $clog2(NPIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic [CFG_W-1:0]  cfg_x_i,
    input  logic [CFG_W-1:0]  cfg_y_i,
    input  logic [SELW-1:0]   cfg_sel_a_i,
    input  logic [SELW-1:0]   cfg_sel_b_i,
    input  logic [NPIN-1:0]   pins_i,
    output logic [ZW-1:0]     z_o,
    output logic              out_en_o,
    output logic              out_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CFG_W-1:0]  x;
        logic [CFG_W-1:0]  y;
        logic [SELW-1:0]   sel_a;
        logic [SELW-1:0]   sel_b;
        logic [ZW-1:0]     z;
        logic              state;
    } regs_t;

    regs_t regs_d, regs_q;

    logic            pin_a, pin_b;
    logic            match;
    logic            toggle;
    logic [OP_W-1:0] eff_op;
    logic [ZW-1:0]   alu_z;
    logic            active;

    pcsm_route #(.NPIN(NPIN)) route_i (
        .pins_i  (pins_i),
        .sel_a_i (regs_q.sel_a),
        .sel_b_i (regs_q.sel_b),
        .a_o     (pin_a),
        .b_o     (pin_b)
    );

    pcsm_opsel opsel_i (
        .a_i       (pin_a),
        .b_i       (pin_b),
        .one_bit_i (regs_q.mode[1]),
        .state_i   (regs_q.state),
        .x_i       (regs_q.x),
        .y_i       (regs_q.y),
        .match_o   (match),
        .eff_op_o  (eff_op),
        .toggle_o  (toggle)
    );

    pcsm_alu #(.ZW(ZW)) alu_i (
        .z_i    (regs_q.z),
        .kind_i (eff_op[2:0]),
        .z_o    (alu_z)
    );

    assign active = (regs_q.mode[4:2] == 3'b101);

    always_comb begin
        regs_d = regs_q;
        if (cfg_we_i) begin
            regs_d.mode  = cfg_mode_i;
            regs_d.x     = cfg_x_i;
            regs_d.y     = cfg_y_i;
            regs_d.sel_a = cfg_sel_a_i;
            regs_d.sel_b = cfg_sel_b_i;
            regs_d.z     = '0;
            regs_d.state = 1'b0;
        end else if (active) begin
            regs_d.z     = alu_z;
            regs_d.state = regs_q.state ^ toggle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign z_o      = regs_q.z;
    assign out_en_o = active & regs_q.mode[0];
    assign out_o    = out_en_o & regs_q.z[0];

    assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (z_o == '0) && !regs_q.state);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cfg_we_i) |=> $stable(z_o));

    assert_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_we_i && !eff_op[3]) |=> $stable(regs_q.state));

    assert_inc_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_we_i && eff_op[2:0] == 3'b100) |=> z_o == $past(z_o) + ZW'(1));

    assert_shl_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_we_i && eff_op[2:0] == 3'b111) |=> !z_o[0]);

    assert_output_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o |-> !out_o);
endmodule

// File: tb/pcsm_engine_tb.sv
module pcsm_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [31:0] x;
        logic [31:0] y;
        logic [7:0]  pins;
        logic [7:0]  steps;
        logic [31:0] exp;
    } vec_t;

    function automatic logic [31:0] mkx(logic [4:0] op, logic tog);
        return {5'b0, tog, op, 21'b0};
    endfunction

    function automatic logic [31:0] mky(logic [4:0] op, logic tog, logic [1:0] pat);
        return {3'b0, pat, tog, op, 21'b0};
    endfunction

    localparam vec_t VECS [10] = '{
        '{mkx(5'b00010,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd1, 32'h1},          // R2 set +1
        '{mkx(5'b00100,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd3, 32'h3},          // R2 inc
        '{mkx(5'b00101,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd1, 32'hFFFF_FFFF},  // R10 dec wrap
        '{mkx(5'b00011,1'b0), mky(5'b00100,1'b0,2'b01), 8'h01, 8'd5, 32'h5},      // R3 match path
        '{mkx(5'b01010,1'b1), mky(5'b0,1'b0,2'b11), 8'h00, 8'd2, 32'hFFFF_FFFF},  // R5 set pair flips
        '{mkx(5'b01100,1'b1), mky(5'b0,1'b0,2'b11), 8'h00, 8'd3, 32'h1},          // R5 inc/dec alternate
        '{mkx(5'b00100,1'b1), mky(5'b0,1'b0,2'b11), 8'h00, 8'd3, 32'h3},          // R6 bit3 clear
        '{mkx(5'b01100,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd4, 32'h4},          // R6 enable clear
        '{mkx(5'b10100,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd2, 32'h2},          // R2 bit4 ignored
        '{mkx(5'b00001,1'b0), mky(5'b0,1'b0,2'b11), 8'h00, 8'd3, 32'h0}           // R2 hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_mode = '0;
    logic [31:0] cfg_x = '0, cfg_y = '0;
    logic [2:0]  cfg_sel_a = 3'd0, cfg_sel_b = 3'd1;
    logic [7:0]  pins = '0;
    logic [31:0] z;
    logic        out_en, out_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcsm_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_mode_i  (cfg_mode),
        .cfg_x_i     (cfg_x),
        .cfg_y_i     (cfg_y),
        .cfg_sel_a_i (cfg_sel_a),
        .cfg_sel_b_i (cfg_sel_b),
        .pins_i      (pins),
        .z_o         (z),
        .out_en_o    (out_en),
        .out_o       (out_pin)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic configure(logic [4:0] m, logic [31:0] x, logic [31:0] y,
                             logic [2:0] sa, logic [2:0] sb);
        cfg_mode = m; cfg_x = x; cfg_y = y; cfg_sel_a = sa; cfg_sel_b = sb;
        cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(logic [7:0] p);
        pins = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 z after reset", z, 32'h0);
        check("R1 out_en after reset", {31'b0, out_en}, 32'h0);
        check("R1 out after reset", {31'b0, out_pin}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle mode holds z", z, 32'h0);

        foreach (VECS[i]) begin
            configure(5'b10101, VECS[i].x, VECS[i].y, 3'd0, 3'd1);
            check($sformatf("R9 vector %0d cleared", i), z, 32'h0);
            for (int s = 0; s < int'(VECS[i].steps); s++) step(VECS[i].pins);
            check($sformatf("R2/R3/R5/R6 vector %0d z", i), z, VECS[i].exp);
            check($sformatf("R8 vector %0d out pin", i), {31'b0, out_pin}, {31'b0, VECS[i].exp[0]});
        end

        // R2 shift right with zero fill, R3 path switch
        configure(5'b10101, mkx(5'b00011,1'b0), mky(5'b00110,1'b0,2'b01), 3'd0, 3'd1);
        step(8'h00);
        check("R3 no-match path sets -1", z, 32'hFFFF_FFFF);
        step(8'h01);
        check("R2 shr zero fill", z, 32'h7FFF_FFFF);
        check("R8 out follows z0", {31'b0, out_pin}, 32'h1);

        // R2 shift left with zero fill
        configure(5'b10101, mkx(5'b00011,1'b0), mky(5'b00111,1'b0,2'b01), 3'd0, 3'd1);
        step(8'h00);
        step(8'h01);
        check("R2 shl zero fill", z, 32'hFFFF_FFFE);
        check("R8 out low when z0 low", {31'b0, out_pin}, 32'h0);

        // R10 increment wraps to zero (bit4 set in X opcode)
        configure(5'b10101, mkx(5'b10011,1'b0), mky(5'b00100,1'b0,2'b00), 3'd0, 3'd1);
        step(8'h01);
        check("R10 preload all ones", z, 32'hFFFF_FFFF);
        step(8'h00);
        check("R10 inc wraps", z, 32'h0);

        // R4 one-bit two-pattern mode
        configure(5'b10111, mkx(5'b00000,1'b0), mky(5'b01100,1'b1,2'b01), 3'd0, 3'd1);
        step(8'h01);
        check("R4 state0 match inc", z, 32'h1);
        step(8'h03);
        check("R4 state1 A=1 no match holds", z, 32'h1);
        step(8'h00);
        check("R4 state1 A=0 match dec", z, 32'h0);
        step(8'h01);
        check("R4 back in state0 inc", z, 32'h1);

        // R7 pin routing: A from pin 5, B from pin 2, pattern {B,A}=10
        configure(5'b10101, mkx(5'b00000,1'b0), mky(5'b00100,1'b0,2'b10), 3'd5, 3'd1 + 3'd1);
        step(8'b0000_0111);
        check("R7 routed match", z, 32'h1);
        step(8'b0010_0100);
        check("R7 A pin high no match", z, 32'h1);
        step(8'b0000_0000);
        check("R7 B pin low no match", z, 32'h1);

        // R8 idle mode and non-output mode
        configure(5'b00000, mkx(5'b00010,1'b0), mky(5'b0,1'b0,2'b11), 3'd0, 3'd1);
        step(8'h00); step(8'h00);
        check("R8 idle mode holds z", z, 32'h0);
        check("R8 idle out_en low", {31'b0, out_en}, 32'h0);
        configure(5'b10100, mkx(5'b00011,1'b0), mky(5'b0,1'b0,2'b11), 3'd0, 3'd1);
        step(8'h00);
        check("R8 mode 10100 runs", z, 32'hFFFF_FFFF);
        check("R8 mode 10100 out_en low", {31'b0, out_en}, 32'h0);
        check("R8 mode 10100 out low", {31'b0, out_pin}, 32'h0);

        // R9 write clears state: enter state 1, then rewrite
        configure(5'b10101, mkx(5'b01100,1'b1), mky(5'b0,1'b0,2'b11), 3'd0, 3'd1);
        step(8'h00);
        configure(5'b10101, mkx(5'b01100,1'b1), mky(5'b0,1'b0,2'b11), 3'd0, 3'd1);
        check("R9 rewrite clears z", z, 32'h0);
        step(8'h00);
        check("R9 state cleared so inc", z, 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule